// File: doc/BRIEF.md
# Multi-mode 8x8 multiplier

This block forms the 16-bit product of two 8-bit operands. A three-bit mode input chooses how the operands are read. They can both be unsigned, both two's-complement signed, or operand A signed with operand B unsigned. Each of these three can be taken as integers or as 1.7 fixed-point fractions. In the fractional forms the product is moved up one bit, so the result keeps 1.15 alignment.

A one-cycle `start` pulse captures the mode and both operands. Two clock cycles later `done` pulses for one cycle, and the product, carry flag and zero flag are valid on that cycle. Those outputs keep their values until the next result arrives.

The block accepts no new work while a multiplication is in flight. A `start` that arrives before `done` is simply dropped. A `start` on the same cycle as `done` is accepted. All pins are plain control and data pins, and no valid/ready handshake is used. The operand width is a parameter that defaults to 8.

Top module: `mm_mul8`

## Requirements
- R1: With mode bits [1:0] = 00 and mode bit [2] = 0, product equals op_a times op_b, with both read as unsigned integers.
- R2: With mode bits [1:0] = 01 and bit [2] = 0, product is the 16-bit two's-complement result of op_a times op_b, with both read as signed integers.
- R3: With mode bits [1:0] = 10 and bit [2] = 0, product is the 16-bit two's-complement result of signed op_a times unsigned op_b.
- R4: With mode bit [2] = 1, the raw product for the signedness chosen by bits [1:0] is shifted left by one bit. Raw bit 15 is dropped and bit 0 becomes 0.
- R5: carry equals bit 15 of the raw product, taken before any fractional shift.
- R6: zero is 1 exactly when the final 16-bit product is 0x0000.
- R7: A start accepted on a clock edge makes done high for exactly one cycle. That cycle begins at the second rising edge after the accepting edge, and the results are valid in it.
- R8: A start raised while a multiplication is in flight, and before done, is ignored. It produces no extra done pulse and does not alter the result in flight.
- R9: Mode bits [1:0] = 11 behave as unsigned × unsigned.
- R10: After reset, product, done, carry and zero are all 0. Product, carry and zero change only on a cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted when idle |
| mode | input | 3 | [1:0] signedness select, [2] fractional select |
| op_a | input | W | Operand A |
| op_b | input | W | Operand B |
| product | output | 2W | Final product |
| done | output | 1 | One-cycle result strobe |
| carry | output | 1 | Bit 2W-1 of the raw product |
| zero | output | 1 | Final product is zero |

## Verification
The bench builds the block with its default width of 8. At that width every sign corner can be reached directly: -128 times -128 (which overflows to 0x8000 in fractional form), -1 times 255 in the mixed mode, and fractional cases where the raw bit 15 and the shifted bit 15 differ. Those differing cases separate the carry source from the final product. A start pulse held through the busy cycle tests that the request is dropped. The exact done cycle is sampled on both sides to pin the two-cycle latency.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    SEL_UU  = 2'b00,
    SEL_SS  = 2'b01,
    SEL_SU  = 2'b10,
    SEL_RSV = 2'b11
  } sign_sel_e;

  localparam int unsigned MODE_W = 3;
  localparam int unsigned FRAC_BIT = 2;

  function automatic logic a_is_signed(input sign_sel_e s);
    return (s == SEL_SS) || (s == SEL_SU);
  endfunction

  function automatic logic b_is_signed(input sign_sel_e s);
    return (s == SEL_SS);
  endfunction

endpackage

// File: rtl/mm_operand_ext.sv
module mm_operand_ext #(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic [W-1:0]  val,
  input  logic          is_signed,
  output logic [PW-1:0] ext
);
  logic fill;
  assign fill = is_signed & val[W-1];
  assign ext  = {{W{fill}}, val};
endmodule

// File: rtl/mm_product.sv
module mm_product #(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic [PW-1:0] ea,
  input  logic [PW-1:0] eb,
  output logic [PW-1:0] raw
);
  // Low PW bits of a PW x PW product are the same for signed and unsigned
  // readings, so extended operands need only one unsigned multiplier.
  assign raw = ea * eb;
endmodule

// File: rtl/mm_post.sv
module mm_post #(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic [PW-1:0] raw,
  input  logic          frac,
  output logic [PW-1:0] result,
  output logic          carry,
  output logic          zero
);
  always_comb begin
    if (frac) result = {raw[PW-2:0], 1'b0};
    else      result = raw;
  end
  assign carry = raw[PW-1];
  assign zero  = (result == '0);
endmodule

// File: rtl/mm_mul8.sv
module mm_mul8
  import mm_pkg::*;
#(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  output logic [PW-1:0]     product,
  output logic              done,
  output logic              carry,
  output logic              zero
);

  sign_sel_e sel;
  logic      accept;
  logic [PW-1:0] ea, eb;

  assign sel    = sign_sel_e'(mode[1:0]);
  assign accept = start & ~s1_valid;

  mm_operand_ext #(.W(W)) i_ext_a (.val(op_a), .is_signed(a_is_signed(sel)), .ext(ea));
  mm_operand_ext #(.W(W)) i_ext_b (.val(op_b), .is_signed(b_is_signed(sel)), .ext(eb));

  // Stage 1: captured operands
  logic          s1_valid;
  logic          s1_frac;
  logic [PW-1:0] s1_ea, s1_eb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_frac  <= 1'b0;
      s1_ea    <= '0;
      s1_eb    <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_frac <= mode[FRAC_BIT];
        s1_ea   <= ea;
        s1_eb   <= eb;
      end
    end
  end

  // Stage 2: multiply, align, flags
  logic [PW-1:0] raw, res;
  logic          c_nxt, z_nxt;

  mm_product #(.W(W)) i_prod (.ea(s1_ea), .eb(s1_eb), .raw(raw));
  mm_post    #(.W(W)) i_post (.raw(raw), .frac(s1_frac), .result(res),
                              .carry(c_nxt), .zero(z_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
      carry   <= 1'b0;
      zero    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= s1_valid;
      if (s1_valid) begin
        product <= res;
        carry   <= c_nxt;
        zero    <= z_nxt;
      end
    end
  end

  // R7: accepted start gives done two edges later, as a single pulse
  a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !s1_valid) |=> ##1 done);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: a start during the busy cycle leaves no new work behind
  a_r8_busy_drops_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && s1_valid) |=> (done && !s1_valid));
  // R10: results hold between done strobes
  a_r10_hold_product: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(product) && $stable(carry) && $stable(zero)));
  // R6: zero flag agrees with the delivered product
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (zero == (product == '0)));

endmodule

// File: tb/test_mm_mul8.sv
module test_mm_mul8;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic [2:0]  m;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] p;
    logic        c;
    logic        z;
  } vec_t;

  // mode: [1:0] 00 uu, 01 ss, 10 su, 11 treated as uu; [2] fractional
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'hFF, 8'hFF, 16'hFE01, 1'b1, 1'b0},  // R1
    '{3'd0, 8'h00, 8'h5A, 16'h0000, 1'b0, 1'b1},  // R1 R6
    '{3'd1, 8'hFF, 8'hFF, 16'h0001, 1'b0, 1'b0},  // R2
    '{3'd1, 8'h80, 8'h7F, 16'hC080, 1'b1, 1'b0},  // R2
    '{3'd1, 8'h07, 8'hFB, 16'hFFDD, 1'b1, 1'b0},  // R2
    '{3'd2, 8'hFF, 8'hFF, 16'hFF01, 1'b1, 1'b0},  // R3
    '{3'd3, 8'h80, 8'hFF, 16'h7F80, 1'b0, 1'b0},  // R9
    '{3'd4, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},  // R4
    '{3'd4, 8'h80, 8'hFF, 16'hFF00, 1'b0, 1'b0},  // R4 R5
    '{3'd4, 8'hFF, 8'hFF, 16'hFC02, 1'b1, 1'b0},  // R4 R5
    '{3'd5, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},  // R4
    '{3'd5, 8'h40, 8'hC0, 16'hE000, 1'b1, 1'b0},  // R4 R5
    '{3'd5, 8'h80, 8'h00, 16'h0000, 1'b0, 1'b1},  // R6
    '{3'd6, 8'hC0, 8'h80, 16'hC000, 1'b1, 1'b0}   // R3 R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [7:0]  op_a = '0, op_b = '0;
  logic [15:0] product;
  logic        done, carry, zero;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_mul8 i_mm_mul8 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .op_a(op_a), .op_b(op_b), .product(product), .done(done),
    .carry(carry), .zero(zero)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive on falling edge; result sampled after the second rising edge.
  task automatic run(input string req, input logic [2:0] m, input logic [7:0] a,
                     input logic [7:0] b, input logic [15:0] p, input logic c,
                     input logic z);
    @(negedge clk);
    start = 1'b1; mode = m; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R7 no early done"}, done, 0);
    @(negedge clk);
    chk({req, " R7 done"}, done, 1);
    chk({req, " product"}, product, p);
    chk({req, " R5 carry"}, carry, c);
    chk({req, " R6 zero"}, zero, z);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R10 reset product", product, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset flags", {carry, zero}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run("vector", VECS[i].m, VECS[i].a, VECS[i].b, VECS[i].p, VECS[i].c, VECS[i].z);

    // R7: single-cycle done strobe, R10: value held afterwards
    @(negedge clk);
    chk("R7 done pulse one cycle", done, 0);
    chk("R10 product held", product, 16'hC000);

    // R8: second start during busy cycle is dropped
    @(negedge clk);
    start = 1'b1; mode = 3'd0; op_a = 8'h03; op_b = 8'h05;
    @(negedge clk);
    mode = 3'd0; op_a = 8'hFF; op_b = 8'hFF;     // still requesting while busy
    @(negedge clk);
    start = 1'b0;
    chk("R8 first done", done, 1);
    chk("R8 first result kept", product, 16'h000F);
    @(negedge clk);
    chk("R8 no extra done", done, 0);
    @(negedge clk);
    chk("R8 no extra done later", done, 0);
    chk("R8 product unchanged", product, 16'h000F);

    // R7: back-to-back, start accepted on the done cycle
    @(negedge clk);
    start = 1'b1; mode = 3'd1; op_a = 8'h02; op_b = 8'hFE;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R7 first of pair", product, 16'hFFFC);
    start = 1'b1; mode = 3'd2; op_a = 8'h02; op_b = 8'hFE;
    @(negedge clk);
    start = 1'b0;
    chk("R7 gap after pair", done, 0);
    @(negedge clk);
    chk("R7 second of pair done", done, 1);
    chk("R3 second of pair", product, 16'h01FC);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule